// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block sits between eight external interrupt pins and an interrupt controller. Each pin is first brought into the clock domain through a two-flop synchroniser. A per-line detector then turns the synchronised level into a request signal. Each line has its own programmable trigger condition: a low level, a high level, a rising edge or a falling edge. In the two level modes the request follows the pin. In the two edge modes the request is a one-cycle pulse. The request outputs carry no memory. Latching, clearing and prioritising requests is the controller's job, so a request that a level line has raised is not withdrawn by this block.

Each line's trigger condition is a 2-bit code. The codes are packed four to a byte into two mode registers. Software reads and writes these registers through a small byte-wide register port. The port has a write strobe and a combinational read path. Every offset that is not a mode register reads as zero and ignores writes.

Top module: `xtrig_detect`

## Requirements
- R1: Trigger code 0 selects active-low level: the line's request is high in every cycle in which its synchronised input is 0.
- R2: Trigger code 1 selects active-high level: the line's request is high in every cycle in which its synchronised input is 1.
- R3: Trigger code 2 selects rising edge: a 0-to-1 change of the synchronised input produces a request pulse exactly one cycle long, and nothing else produces a request.
- R4: Trigger code 3 selects falling edge: a 1-to-0 change of the synchronised input produces a request pulse exactly one cycle long.
- R5: The mode register at offset 0 holds lines 0 to 3 and the one at offset 1 holds lines 4 to 7. Within a register, local line k takes bits 2k+1:2k.
- R6: After reset every line's code is 3 (falling edge), so both mode registers read 0xFF, and no request is raised.
- R7: A write to offset 0 or 1 takes effect on the next clock, and reading that offset afterwards returns the written byte.
- R8: Offsets other than 0 and 1 read as 0x00, and writes to them change no mode and no request.
- R9: Each pin passes through two synchronising flops. A pin change is first visible at the request output after the second rising clock edge following the change.
- R10: Changing a line's code while its synchronised input is steady produces no edge pulse on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Raw external interrupt pins, asynchronous |
| reg_addr_i | input | 3 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| req_o | output | 8 | Per-line request to the interrupt controller |

## Verification
The bench builds the block with its default parameters: eight lines, four lines per mode register, two synchroniser stages and a 3-bit offset. With these values both mode registers are exercised, and so are six unmapped offsets (2 to 7). That covers R8 at every address the port can present. The two-stage setting fixes the request latency at two edges, which the cycle-exact scoreboard relies on. Mixing all four codes across the two registers lets a single pin pattern exercise both levels and both edges at the same time.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

    localparam int MODE_W = 2;
    localparam int BYTE_W = 8;

    typedef enum logic [MODE_W-1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic now;
        logic prev;
    } line_hist_t;

    function automatic logic eval_trigger(trig_mode_e mode, line_hist_t h);
        logic hit;
        case (mode)
            TRIG_LOW:  hit = ~h.now;
            TRIG_HIGH: hit = h.now;
            TRIG_RISE: hit = h.now & ~h.prev;
            default:   hit = ~h.now & h.prev;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/xtrig_sync.sv
module xtrig_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            logic [1:0] warm_q;
            always_ff @(posedge clk) begin
                if (rst) warm_q <= '0;
                else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
            end
            // R9
            sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
                (warm_q == 2'd3) |-> (q_o == $past(d_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/xtrig_mode_regs.sv
module xtrig_mode_regs
    import xtrig_pkg::*;
#(
    parameter int N_LINES       = 8,
    parameter int LINES_PER_REG = 4,
    parameter int ADDR_W        = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      wr_i,
    input  logic [BYTE_W-1:0]         wdata_i,
    output logic [BYTE_W-1:0]         rdata_o,
    output logic [N_LINES*MODE_W-1:0] mode_vec_o
);

    localparam int N_REGS   = N_LINES / LINES_PER_REG;
    localparam int REG_BITS = LINES_PER_REG * MODE_W;

    logic [N_LINES*MODE_W-1:0] mode_vec_q;
    logic                      addr_hit;

    generate
        for (genvar r = 0; r < N_REGS; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    mode_vec_q[r*REG_BITS +: REG_BITS] <= {LINES_PER_REG{TRIG_FALL}};
                else if (wr_i && addr_i == ADDR_W'(r))
                    mode_vec_q[r*REG_BITS +: REG_BITS] <= wdata_i[REG_BITS-1:0];
            end

            // R5
            reg_write_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_i && addr_i == ADDR_W'(r)) |=>
                (mode_vec_q[r*REG_BITS +: REG_BITS] == $past(wdata_i[REG_BITS-1:0])));
        end
    endgenerate

    always_comb begin
        rdata_o  = '0;
        addr_hit = 1'b0;
        for (int r = 0; r < N_REGS; r++) begin
            if (addr_i == ADDR_W'(r)) begin
                rdata_o  = BYTE_W'(mode_vec_q[r*REG_BITS +: REG_BITS]);
                addr_hit = 1'b1;
            end
        end
    end

    assign mode_vec_o = mode_vec_q;

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !addr_hit) |=> $stable(mode_vec_q));

    // R6
    reset_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_vec_q == {N_LINES{TRIG_FALL}}));

endmodule

// File: rtl/xtrig_line.sv
module xtrig_line
    import xtrig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode_i,
    input  logic       sync_i,
    output logic       req_o
);

    logic       prev_q;
    line_hist_t hist;

    // History always tracks the synchronised input, so a mode change
    // compares against the present level and sees no edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_i;
    end

    always_comb begin
        hist.now  = sync_i;
        hist.prev = prev_q;
        req_o     = eval_trigger(mode_i, hist);
    end

    // R3
    rise_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == TRIG_RISE && req_o) |=> !(mode_i == TRIG_RISE && req_o));

    // R4
    fall_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == TRIG_FALL && req_o) |=> !(mode_i == TRIG_FALL && req_o));

    // R10
    mode_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mode_i) && sync_i == prev_q &&
         (mode_i == TRIG_RISE || mode_i == TRIG_FALL)) |-> !req_o);

endmodule

// File: rtl/xtrig_detect.sv
module xtrig_detect
    import xtrig_pkg::*;
#(
    parameter int N_LINES       = 8,
    parameter int LINES_PER_REG = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int ADDR_W        = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] pin_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [BYTE_W-1:0]  reg_wdata_i,
    output logic [BYTE_W-1:0]  reg_rdata_o,
    output logic [N_LINES-1:0] req_o
);

    logic [N_LINES-1:0]        pin_sync;
    logic [N_LINES*MODE_W-1:0] mode_vec;

    xtrig_sync #(
        .WIDTH  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_sync)
    );

    xtrig_mode_regs #(
        .N_LINES       (N_LINES),
        .LINES_PER_REG (LINES_PER_REG),
        .ADDR_W        (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (reg_addr_i),
        .wr_i       (reg_wr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .mode_vec_o (mode_vec)
    );

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_line
            xtrig_line u_line (
                .clk    (clk),
                .rst    (rst),
                .mode_i (trig_mode_e'(mode_vec[i*MODE_W +: MODE_W])),
                .sync_i (pin_sync[i]),
                .req_o  (req_o[i])
            );
        end
    endgenerate

    // R6
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_o == '0));

endmodule

// File: tb/test_xtrig_detect.sv
module test_xtrig_detect;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin = 8'h00;
    logic [2:0] addr = 3'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_tag = "R9";

    always #5 clk = ~clk;

    xtrig_detect i_xtrig_detect (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .req_o       (req)
    );

    // Reference model and scoreboard queues
    logic [7:0]  m_s1, m_s, m_h;
    logic [15:0] m_mode;
    logic [7:0]  exp_q [$];
    string       tag_q [$];

    always @(posedge clk) begin
        logic [7:0] e;
        if (rst) begin
            m_s1 = '0; m_s = '0; m_h = '0; m_mode = 16'hFFFF;
        end else begin
            m_h  = m_s;
            m_s  = m_s1;
            m_s1 = pin;
            if (wr && addr == 3'd0) m_mode[7:0]  = wdata;
            if (wr && addr == 3'd1) m_mode[15:8] = wdata;
            for (int i = 0; i < 8; i++) begin
                case (m_mode[2*i +: 2])
                    2'd0: e[i] = !m_s[i];
                    2'd1: e[i] = m_s[i];
                    2'd2: e[i] = m_s[i] && !m_h[i];
                    default: e[i] = !m_s[i] && m_h[i];
                endcase
            end
            exp_q.push_back(e);
            tag_q.push_back(cur_tag);
        end
    end

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (req !== e) begin
                errors++;
                $display("FAIL %s req actual=%h expected=%h", t, req, e);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic read_check(logic [2:0] a, logic [7:0] e, string t);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s read offset %0d actual=%h expected=%h", t, a, rdata, e);
        end
    endtask

    task automatic drive(logic [7:0] p, int hold);
        @(negedge clk);
        pin = p;
        step(hold);
    endtask

    initial begin
        step(4);
        // R6: reset state
        checks++;
        if (req !== 8'h00) begin
            errors++;
            $display("FAIL R6 req in reset actual=%h expected=00", req);
        end
        read_check(3'd0, 8'hFF, "R6");
        read_check(3'd1, 8'hFF, "R6");
        @(negedge clk);
        rst = 1'b0;
        cur_tag = "R6";
        step(4);

        // R4: default falling edge on all lines
        cur_tag = "R4";
        drive(8'hFF, 5);
        drive(8'h00, 5);
        drive(8'hA5, 1);
        drive(8'h5A, 4);

        // R7 / R5: program a mix of codes and read back
        cur_tag = "R5";
        write_reg(3'd0, 8'hE4);  // line0 low, line1 high, line2 rise, line3 fall
        write_reg(3'd1, 8'h1B);  // line4 fall, line5 rise, line6 high, line7 low
        read_check(3'd0, 8'hE4, "R7");
        read_check(3'd1, 8'h1B, "R7");

        // R1 R2 R3 R4 R5: patterns over the mixed configuration
        cur_tag = "R1 R2 R3 R5";
        drive(8'h00, 4);
        drive(8'hFF, 4);
        drive(8'h00, 3);
        drive(8'h0F, 2);
        drive(8'hF0, 2);
        drive(8'h33, 1);
        drive(8'hCC, 1);
        drive(8'h55, 3);

        // R9: single-line toggle latency
        cur_tag = "R9";
        drive(8'h00, 4);
        drive(8'h04, 5);
        drive(8'h00, 5);

        // R8: unmapped offsets
        cur_tag = "R8";
        for (int a = 2; a < 8; a++) write_reg(3'(a), 8'h00);
        for (int a = 2; a < 8; a++) read_check(3'(a), 8'h00, "R8");
        read_check(3'd0, 8'hE4, "R8");
        read_check(3'd1, 8'h1B, "R8");
        drive(8'hFF, 4);

        // R10: mode changes with steady inputs
        cur_tag = "R10";
        write_reg(3'd0, 8'hFF);
        write_reg(3'd1, 8'hFF);
        step(2);
        write_reg(3'd0, 8'hAA);
        write_reg(3'd1, 8'hAA);
        step(2);
        drive(8'h00, 4);
        write_reg(3'd0, 8'hFF);
        write_reg(3'd1, 8'h55);
        step(3);
        write_reg(3'd1, 8'hFF);
        step(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule